// File: doc/BRIEF.md
# Temperature Event Alarm Controller

This block watches a stream of digitized temperature samples. It compares each sample against three programmable limits: the upper and lower bounds of an alarm window, and a critical trip point. The result drives an active-low event output in open-drain style. A low level flags an event and a high level releases the line. Each limit uses a programmable hysteresis that applies only when a condition is released, so a reading that sits near a limit does not make the output chatter.

Software programs the block through a simple write-enable register port. It selects one of three behaviours for the window alarm. In latched-interrupt mode the event stays low until software sends a clear strobe. In tracking (comparator) mode the event follows the temperature. In critical-only mode the window is ignored. The critical condition always tracks the temperature and no clear strobe can remove it. Three status outputs report which conditions are present and a fourth reports a pending latched interrupt. A global output-enable bit gates only the pin: the status outputs keep updating while the output is disabled.

Samples arrive on a valid/ready interface. Ready is low during reset and held high afterwards, so the block never applies back-pressure. A sample is consumed on every clock edge where valid and ready are both high. A source may hold valid high for several cycles; each such cycle counts as a new sample.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: `smp_ready` is low during reset and high from the first clock edge after reset release. The status flags change only at an edge where `smp_valid` and `smp_ready` are both high. A sample presented with `smp_valid` low has no effect.
- R2: A write at `wr_addr` 0 loads the configuration: bit 0 output enable, bit 1 window enable, bits 3:2 mode (0 latched interrupt, 1 tracking, 2 critical-only), bits 5:4 hysteresis code. Addresses 1, 2 and 3 load the upper, lower and critical limits from all 13 bits of `wr_data`, read as two's complement in units of 1/16 °C.
- R3: After reset the configuration is all zero (output disabled, window disabled, latched mode, no hysteresis). The upper limit is 1360 (85 °C), the lower limit is −640 (−40 °C) and the critical limit is 1520 (95 °C). `event_n` is high and all status outputs are low.
- R4: `stat_high` sets on a sample strictly above the upper limit and clears on a sample at or below the upper limit minus the hysteresis. Between those two points it holds.
- R5: `stat_low` sets on a sample strictly below the lower limit and clears on a sample at or above the lower limit plus the hysteresis. Between those two points it holds.
- R6: `stat_crit` sets on a sample strictly above the critical limit and clears on a sample at or below the critical limit minus the hysteresis. Hysteresis codes 0, 1, 2 and 3 mean 0, 24, 48 and 96 LSB (0, 1.5, 3 and 6 °C).
- R7: In tracking mode the event is active while `stat_crit` is set, or while the window is enabled and `stat_high` or `stat_low` is set.
- R8: In latched mode, `int_pend` sets on any accepted sample that leaves `stat_high` or `stat_low` set while the window is enabled. It clears on `sw_clr`, and a set at the same edge wins over the clear. After a clear, a later out-of-window sample sets it again. `int_pend` is forced low at every edge where the stored mode is not latched. The event is active while `int_pend` or `stat_crit` is set.
- R9: In critical-only mode, and for mode code 3, only `stat_crit` makes the event active, whatever the state of the window flags.
- R10: `stat_crit` is never affected by `sw_clr`. While it is set and the output is enabled, `event_n` is low in every mode.
- R11: `event_n` is low exactly when the output enable is set and the event is active. It takes its new value in the same cycle as the state that causes it. With the output disabled, `event_n` stays high while the status outputs keep updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Temperature sample valid |
| smp_ready | output | 1 | Sample accepted when high together with valid |
| smp_temp | input | 13 | Signed temperature, 1/16 °C per LSB |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 config, 1 upper, 2 lower, 3 critical |
| wr_data | input | 13 | Register write data |
| sw_clr | input | 1 | Software clear of a latched interrupt |
| event_n | output | 1 | Active-low event output |
| stat_crit | output | 1 | Critical condition present |
| stat_high | output | 1 | Above-window condition present |
| stat_low | output | 1 | Below-window condition present |
| int_pend | output | 1 | Latched window interrupt pending |

## Verification
The checker enforces, on every cycle, the following invariants:
- `event_n` never falls while the output is disabled.
- An enabled critical condition always pulls `event_n` low.
- Critical-only modes never assert the event without a critical condition.
- The status flags hold on every cycle without an accepted sample.
- A clear with no new sample drops a pending interrupt.
- Ready stays high after reset.

Only the scenarios can show the following:
- The exact set and release thresholds at each hysteresis code, including the hold band between them.
- A latch that is set again after a clear while the temperature is still out of the window.
- The one-cycle lag before a mode change drops a pending interrupt.

// File: rtl/talm_pkg.sv
package talm_pkg;

  typedef enum logic [1:0] {
    MODE_LATCH    = 2'd0,
    MODE_TRACK    = 2'd1,
    MODE_CRIT     = 2'd2,
    MODE_CRIT_ALT = 2'd3
  } mode_e;

  // Packed from MSB down: hysteresis code, mode, window enable, output enable
  typedef struct packed {
    logic [1:0] hyst;
    mode_e      mode;
    logic       win_en;
    logic       out_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Flag slot indices shared by the limit comparators and the event logic
  localparam int IDX_LOW  = 0;
  localparam int IDX_HIGH = 1;
  localparam int IDX_CRIT = 2;
  localparam int N_LIM    = 3;

  localparam int HYST_W = 7;

  // Hysteresis in LSB steps of 1/16 degree
  function automatic logic [HYST_W-1:0] hyst_steps(input logic [1:0] code);
    case (code)
      2'd0:    hyst_steps = 7'd0;
      2'd1:    hyst_steps = 7'd24;
      2'd2:    hyst_steps = 7'd48;
      default: hyst_steps = 7'd96;
    endcase
  endfunction

endpackage

// File: rtl/talm_regs.sv
module talm_regs
  import talm_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int RST_UPPER = 1360,
  parameter int RST_LOWER = -640,
  parameter int RST_CRIT  = 1520
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [TEMP_W-1:0]        wr_data,
  output cfg_t                     cfg_q,
  output logic signed [TEMP_W-1:0] upper_q,
  output logic signed [TEMP_W-1:0] lower_q,
  output logic signed [TEMP_W-1:0] crit_q
);

  localparam logic [1:0] A_CFG   = 2'd0;
  localparam logic [1:0] A_UPPER = 2'd1;
  localparam logic [1:0] A_LOWER = 2'd2;
  localparam logic [1:0] A_CRIT  = 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      upper_q <= TEMP_W'(RST_UPPER);
      lower_q <= TEMP_W'(RST_LOWER);
      crit_q  <= TEMP_W'(RST_CRIT);
    end else if (wr_en) begin
      case (wr_addr)
        A_CFG:   cfg_q   <= cfg_t'(wr_data[CFG_W-1:0]);
        A_UPPER: upper_q <= wr_data;
        A_LOWER: lower_q <= wr_data;
        A_CRIT:  crit_q  <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/talm_limit.sv
module talm_limit #(
  parameter int TEMP_W = 13,
  parameter bit ABOVE  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc,
  input  logic signed [TEMP_W-1:0] temp,
  input  logic signed [TEMP_W-1:0] limit,
  input  logic signed [TEMP_W:0]   hyst,
  output logic                     flag_q,
  output logic                     flag_nxt
);

  localparam int EW = TEMP_W + 1;

  logic signed [EW-1:0] t_x, l_x, rel_x;
  logic trip, rel_ok;

  assign t_x = {temp[TEMP_W-1], temp};
  assign l_x = {limit[TEMP_W-1], limit};

  generate
    if (ABOVE) begin : g_above
      assign rel_x  = l_x - hyst;
      assign trip   = t_x > l_x;
      assign rel_ok = t_x <= rel_x;
    end else begin : g_below
      assign rel_x  = l_x + hyst;
      assign trip   = t_x < l_x;
      assign rel_ok = t_x >= rel_x;
    end
  endgenerate

  always_comb begin
    flag_nxt = flag_q;
    if (acc) begin
      if (trip)        flag_nxt = 1'b1;
      else if (rel_ok) flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end

endmodule

// File: rtl/talm_event.sv
module talm_event
  import talm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             acc,
  input  logic             sw_clr,
  input  logic [N_LIM-1:0] flag_q,
  input  logic [N_LIM-1:0] flag_nxt,
  output logic             int_q,
  output logic             active
);

  logic win_nxt, win_now;

  assign win_nxt = cfg.win_en & (flag_nxt[IDX_HIGH] | flag_nxt[IDX_LOW]);
  assign win_now = cfg.win_en & (flag_q[IDX_HIGH]   | flag_q[IDX_LOW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    int_q <= 1'b0;
    else if (cfg.mode != MODE_LATCH) int_q <= 1'b0;
    else if (acc && win_nxt)       int_q <= 1'b1;
    else if (sw_clr)               int_q <= 1'b0;
  end

  always_comb begin
    active = flag_q[IDX_CRIT];
    case (cfg.mode)
      MODE_LATCH: active = active | int_q;
      MODE_TRACK: active = active | win_now;
      default:    ;
    endcase
  end

endmodule

// File: rtl/temp_alarm_ctrl.sv
module temp_alarm_ctrl
  import talm_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int RST_UPPER = 1360,
  parameter int RST_LOWER = -640,
  parameter int RST_CRIT  = 1520
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  output logic                     smp_ready,
  input  logic signed [TEMP_W-1:0] smp_temp,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [TEMP_W-1:0]        wr_data,
  input  logic                     sw_clr,
  output logic                     event_n,
  output logic                     stat_crit,
  output logic                     stat_high,
  output logic                     stat_low,
  output logic                     int_pend
);

  localparam int EW = TEMP_W + 1;

  cfg_t                     cfg_q;
  logic signed [TEMP_W-1:0] upper_q, lower_q, crit_q;
  logic signed [EW-1:0]     hyst_x;
  logic [N_LIM-1:0][TEMP_W-1:0] lim_arr;
  logic [N_LIM-1:0]         flag_q, flag_nxt;
  logic                     ready_q, acc, active, int_q;
  logic                     cfg_out_en;
  mode_e                    cfg_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign smp_ready = ready_q;
  assign acc       = smp_valid & ready_q;

  talm_regs #(
    .TEMP_W(TEMP_W), .RST_UPPER(RST_UPPER),
    .RST_LOWER(RST_LOWER), .RST_CRIT(RST_CRIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_q(cfg_q), .upper_q(upper_q),
    .lower_q(lower_q), .crit_q(crit_q)
  );

  assign hyst_x = signed'({{(EW-HYST_W){1'b0}}, hyst_steps(cfg_q.hyst)});

  assign lim_arr[IDX_LOW]  = lower_q;
  assign lim_arr[IDX_HIGH] = upper_q;
  assign lim_arr[IDX_CRIT] = crit_q;

  for (genvar i = 0; i < N_LIM; i++) begin : g_lim
    talm_limit #(.TEMP_W(TEMP_W), .ABOVE(i != IDX_LOW)) u_lim (
      .clk(clk), .rst_n(rst_n), .acc(acc), .temp(smp_temp),
      .limit(signed'(lim_arr[i])), .hyst(hyst_x),
      .flag_q(flag_q[i]), .flag_nxt(flag_nxt[i])
    );
  end

  talm_event u_evt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .acc(acc), .sw_clr(sw_clr),
    .flag_q(flag_q), .flag_nxt(flag_nxt), .int_q(int_q), .active(active)
  );

  assign cfg_out_en = cfg_q.out_en;
  assign cfg_mode   = cfg_q.mode;

  assign event_n   = ~(cfg_out_en & active);
  assign stat_crit = flag_q[IDX_CRIT];
  assign stat_high = flag_q[IDX_HIGH];
  assign stat_low  = flag_q[IDX_LOW];
  assign int_pend  = int_q;

endmodule

// File: rtl/talm_checks.sv
module talm_checks
  import talm_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  smp_valid,
  input logic  smp_ready,
  input logic  sw_clr,
  input logic  event_n,
  input logic  stat_crit,
  input logic  stat_high,
  input logic  stat_low,
  input logic  int_pend,
  input logic  out_en,
  input mode_e mode
);

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready);

  assert_flags_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_ready) |=> $stable({stat_crit, stat_high, stat_low}));

  assert_clear_drops_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && sw_clr && !(smp_valid && smp_ready)) |=> !int_pend);

  assert_crit_only_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_CRIT || mode == MODE_CRIT_ALT) && !event_n) |-> stat_crit);

  assert_crit_forces_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_crit && out_en) |-> !event_n);

  assert_disabled_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> event_n);

endmodule

bind temp_alarm_ctrl talm_checks u_checks (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .sw_clr(sw_clr), .event_n(event_n), .stat_crit(stat_crit),
  .stat_high(stat_high), .stat_low(stat_low), .int_pend(int_pend),
  .out_en(cfg_out_en), .mode(cfg_mode)
);

// File: tb/temp_alarm_ctrl_test.sv
module temp_alarm_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic signed [12:0] smp_temp = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic sw_clr = 1'b0;
  logic event_n, stat_crit, stat_high, stat_low, int_pend;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  int m_cfg = 0;
  int m_up = 1360, m_lo = -640, m_cr = 1520;
  bit m_hi = 0, m_lw = 0, m_ct = 0, m_int = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  temp_alarm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_temp(smp_temp), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_clr(sw_clr), .event_n(event_n), .stat_crit(stat_crit),
    .stat_high(stat_high), .stat_low(stat_low), .int_pend(int_pend)
  );

  function automatic int hy(int code);
    case (code)
      0: return 0;
      1: return 24;
      2: return 48;
      default: return 96;
    endcase
  endfunction

  function automatic logic [4:0] model_out();
    bit en, win, act;
    int mode;
    en   = m_cfg[0];
    win  = m_cfg[1];
    mode = (m_cfg >> 2) & 3;
    act  = m_ct;
    if (mode == 0) act = act | m_int;
    if (mode == 1) act = act | (win & (m_hi | m_lw));
    return {~(en & act), m_ct, m_hi, m_lw, m_int};
  endfunction

  // Driver: applies one cycle of stimulus, updates the model, queues the expectation
  task automatic step(input bit v, input int t, input bit clr,
                      input bit we, input int wa, input int wd, input string tag);
    int h, mode, ti;
    bit win;
    smp_valid = v; smp_temp = 13'(t); sw_clr = clr;
    wr_en = we; wr_addr = 2'(wa); wr_data = 13'(wd);
    @(posedge clk);
    ti   = int'(smp_temp);
    h    = hy((m_cfg >> 4) & 3);
    mode = (m_cfg >> 2) & 3;
    win  = m_cfg[1];
    if (v) begin
      if (ti > m_up) m_hi = 1; else if (ti <= m_up - h) m_hi = 0;
      if (ti < m_lo) m_lw = 1; else if (ti >= m_lo + h) m_lw = 0;
      if (ti > m_cr) m_ct = 1; else if (ti <= m_cr - h) m_ct = 0;
    end
    if (mode != 0) m_int = 0;
    else if (v && win && (m_hi || m_lw)) m_int = 1;
    else if (clr) m_int = 0;
    if (we) begin
      case (wa)
        0: m_cfg = wd & 63;
        1: m_up = wd;
        2: m_lo = wd;
        default: m_cr = wd;
      endcase
    end
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
    @(negedge clk);
    smp_valid = 0; sw_clr = 0; wr_en = 0;
  endtask

  task automatic smp(input int t, input string tag);
    step(1, t, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input int a, input int d, input string tag);
    step(0, 0, 0, 1, a, d, tag);
  endtask
  task automatic clr(input string tag);
    step(0, 0, 1, 0, 0, 0, tag);
  endtask

  // Monitor: compares outputs against the queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e, a;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      a  = {event_n, stat_crit, stat_high, stat_low, int_pend};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: {event_n,crit,high,low,int} actual=%b expected=%b", tg, a, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_cmp++;
    if ({smp_ready, event_n, stat_crit, stat_high, stat_low, int_pend} !== 6'b110000) begin
      n_bad++;
      $display("FAIL R3/R1 reset: actual=%b expected=110000",
               {smp_ready, event_n, stat_crit, stat_high, stat_low, int_pend});
    end
    // Reset limits: crit 1520 with output disabled
    smp(1521, "R3 default crit limit");
    smp(0, "R3 release");

    // Tracking mode, window on, hyst 0
    wr(1, 800, "R2 upper");
    wr(2, 0, "R2 lower");
    wr(3, 1200, "R2 crit");
    wr(0, 'h07, "R2 cfg track");
    smp(500, "R7 inside");
    smp(801, "R4 above upper");
    smp(800, "R4 release at limit");
    smp(-1, "R5 below lower");
    smp(0, "R5 release at limit");
    smp(1201, "R6 crit set");
    clr("R10 clear ignores crit");
    smp(1200, "R6 crit release");
    step(0, 1500, 0, 0, 0, 0, "R1 invalid sample ignored");

    // Hysteresis 48
    wr(0, 'h27, "R6 hyst code 2");
    smp(850, "R4 hold above");
    smp(780, "R4 hold band");
    smp(752, "R4 release with hyst");
    smp(-640, "R5 below");
    smp(40, "R5 hold band");
    smp(48, "R5 release with hyst");

    // Latched interrupt mode
    wr(0, 'h03, "R8 cfg latch");
    smp(900, "R8 latch set");
    smp(500, "R8 latch holds");
    clr("R8 clear");
    smp(900, "R8 set again");
    step(1, 900, 1, 0, 0, 0, "R8 set beats clear");
    clr("R8 clear while outside");
    smp(900, "R8 reassert after clear");
    smp(1300, "R10 crit in latch mode");
    clr("R10 clear keeps crit event");
    smp(500, "R8 all clear");

    // Output disabled
    wr(0, 'h02, "R11 disable output");
    smp(900, "R11 flags update while disabled");
    wr(0, 'h03, "R11 enable shows latch");
    wr(0, 'h07, "R8 mode change lag");
    step(0, 0, 0, 0, 0, 0, "R8 latch dropped");
    clr("R8 tracking not cleared by sw");

    // Critical-only modes
    wr(0, 'h0B, "R9 cfg crit-only");
    smp(900, "R9 window ignored");
    smp(1250, "R9 crit event");
    wr(0, 'h0F, "R9 mode code 3");
    smp(900, "R9 code 3 window ignored");
    smp(1250, "R9 code 3 crit");

    // Window disabled, hyst 96 on crit
    wr(0, 'h35, "R7 window off hyst 96");
    smp(1110, "R6 hold band crit");
    smp(1104, "R6 release with 96");
    smp(-5, "R7 low flag no event");

    // Negative lower limit
    wr(2, -400, "R2 negative lower");
    wr(0, 'h07, "R7 cfg track");
    smp(-401, "R5 below negative");
    smp(-400, "R5 release negative");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule